// File: doc/BRIEF.md
# Hierarchical Interrupt Aggregation Controller

This block sits on the slave side of a peripheral chip. It gathers up to 64 raw interrupt lines and summarises them in two levels. The lines are grouped eight to a block. Each block is summarised into a master status register, and the masters are then summarised into a root register. A single active-high interrupt output is the OR of the root's master bits. The host reaches the block through a byte-wide register bus. It reads the summaries to find the block that needs service. It then selects that block indirectly and reads the block's latched and real-time status. It programs each line through a single configuration port.

Every line has its own two-flop synchroniser and a small state machine with three states: `LN_OFF` (disabled), `LN_WAIT` (armed, nothing latched) and `LN_PEND` (pending latched).
- `OFF->WAIT`: a qualified configuration write that leaves at least one mask bit clear.
- `WAIT->PEND`: a detected trigger.
- `any->WAIT`: a qualified write with the clear bit set and at least one mask clear.
- `any->OFF`: a qualified write with both mask bits set.
- `PEND` holds until a clear or disable write arrives.
- When a write and a trigger arrive in the same cycle, the write wins.

A trigger is an edge in edge mode and an active level in level mode. Register offsets are counted from the parameter `BASE_ADDR`.

Top module: `irqagg_top`

## Requirements
- R1: After reset every line is in `LN_OFF` with both masks set, edge mode and no pending flag. `irq_out` is 0, `reg_rdata` is 0, and toggling any input latches nothing.
- R2: The register offsets are: +0 root, +1..+4 master status 0..3, +5 block select (read/write), +6 latched status of the selected block, +7 configuration port (reads 0), +8 real-time status of the selected block. A read strobe sampled at a clock edge places the data on `reg_rdata` at that edge, and the data then holds until the next read. Other addresses read 0.
- R3: A configuration byte has these fields: bit0 level mode, bit1 falling/low mask, bit2 rising/high mask, bit3 clear pending, bits 6:4 line index in the selected block, bit7 write qualify. It addresses line 8*blocksel+index. A write with bit7 = 0 has no effect.
- R4: In edge mode, a clear rising mask latches on rising edges and a clear falling mask latches on falling edges. With both masks clear, either edge latches. A masked edge latches nothing.
- R5: In level mode, a clear high mask makes the line active-high and a clear low mask makes it active-low. After a clear, the pending flag is 0 in the cycle after the write and reasserts one cycle later if the input is still active.
- R6: A qualified write with bit3 = 1 drops that line's pending flag in the following cycle.
- R7: A qualified write with both masks set disables the line. Its pending flag drops, it latches no new trigger and it adds nothing to any summary.
- R8: The latched status bit k of the selected block b is the pending flag of line 8*b+k.
- R9: Master i bit j is 1 when block 8*i+j has a pending line. Root bit i+1 is the OR of master i, and root bit 0 always reads 0. Masters beyond ceil(ceil(lines/8)/8) read 0.
- R10: The real-time status returns the synchronised levels of the selected block's eight lines, whatever their configuration.
- R11: `irq_out` is the OR of all pending flags. After an input change, it rises after the third rising clock edge following the change and not before.
- R12: When block select names a block that does not exist, configuration writes change no line, and latched and real-time reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_in | input | NUM_LINES | Raw interrupt lines |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, registered |
| irq_out | output | 1 | Active-high summary interrupt |

## Verification
Several faults all show up as a wrong latched status byte or a wrong summary bit, visible within three cycles of the stimulus. These are a line stuck in the wrong state, a wrong mask decode and a wrong line index. A summary tree that drops a block shows as a master or root byte disagreeing with the latched byte of a block whose status was just read. A fault in clear or re-arm timing is caught by sampling `irq_out` in the exact cycle after a clear write and again one cycle later.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    // register offsets from BASE_ADDR
    localparam logic [3:0] OFF_ROOT = 4'd0;
    localparam logic [3:0] OFF_MST0 = 4'd1;
    localparam logic [3:0] OFF_BSEL = 4'd5;
    localparam logic [3:0] OFF_LAT  = 4'd6;
    localparam logic [3:0] OFF_CFG  = 4'd7;
    localparam logic [3:0] OFF_RT   = 4'd8;
    localparam int         MAX_MST  = 4;

    // configuration byte fields
    localparam int CFG_LVL = 0;
    localparam int CFG_MFE = 1;
    localparam int CFG_MRE = 2;
    localparam int CFG_CLR = 3;
    localparam int CFG_IDX = 4;
    localparam int CFG_WQ  = 7;

    typedef enum logic [1:0] {
        LN_OFF  = 2'd0,
        LN_WAIT = 2'd1,
        LN_PEND = 2'd2
    } line_state_e;

endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_in;
            stage2_q <= stage1_q;
        end
    end

    assign d_out = stage2_q;
endmodule

// File: rtl/irqagg_line.sv
module irqagg_line
    import irqagg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_in,
    input  logic       cfg_we,
    input  logic [7:0] cfg_byte,
    output logic       pending
);
    line_state_e state_q, state_d;
    logic        lvl_q, mfe_q, mre_q, prev_q;
    logic        hit;
    logic        new_off;

    // configuration and edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q  <= 1'b0;
            mfe_q  <= 1'b1;
            mre_q  <= 1'b1;
            prev_q <= 1'b0;
        end else begin
            prev_q <= sync_in;
            if (cfg_we) begin
                lvl_q <= cfg_byte[CFG_LVL];
                mfe_q <= cfg_byte[CFG_MFE];
                mre_q <= cfg_byte[CFG_MRE];
            end
        end
    end

    always_comb begin
        if (lvl_q)
            hit = (!mre_q && sync_in) || (!mfe_q && !sync_in);
        else
            hit = (!mre_q && sync_in && !prev_q) || (!mfe_q && !sync_in && prev_q);
    end

    assign new_off = cfg_byte[CFG_MFE] && cfg_byte[CFG_MRE];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LN_OFF;
        else        state_q <= state_d;
    end

    // next state: configuration writes take priority over triggers
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_OFF:  state_d = LN_OFF;
            LN_WAIT: if (hit) state_d = LN_PEND;
            LN_PEND: state_d = LN_PEND;
            default: state_d = LN_OFF;
        endcase
        if (cfg_we) begin
            if (new_off)
                state_d = LN_OFF;
            else if (cfg_byte[CFG_CLR] || state_q == LN_OFF)
                state_d = LN_WAIT;
            else
                state_d = state_q;
        end
    end

    // outputs
    always_comb begin
        pending = (state_q == LN_PEND);
    end
endmodule

// File: rtl/irqagg_tree.sv
module irqagg_tree #(
    parameter int NUM_BLOCKS  = 8,
    parameter int NUM_MASTERS = 1
) (
    input  logic [NUM_BLOCKS*8-1:0]  pend_pad,
    output logic [NUM_MASTERS*8-1:0] master_vec,
    output logic [7:0]               root,
    output logic                     irq
);
    localparam int MST_BLOCKS = NUM_MASTERS * 8;

    logic [NUM_BLOCKS-1:0] blk_any;

    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
        assign blk_any[b] = |pend_pad[b*8 +: 8];
    end

    for (genvar k = 0; k < MST_BLOCKS; k++) begin : g_mst_bit
        if (k < NUM_BLOCKS) begin : g_real
            assign master_vec[k] = blk_any[k];
        end else begin : g_pad
            assign master_vec[k] = 1'b0;
        end
    end

    for (genvar r = 0; r < 8; r++) begin : g_root
        if (r >= 1 && r <= NUM_MASTERS) begin : g_used
            assign root[r] = |master_vec[(r-1)*8 +: 8];
        end else begin : g_zero
            assign root[r] = 1'b0;
        end
    end

    assign irq = |root;
endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
    import irqagg_pkg::*;
#(
    parameter int                NUM_LINES   = 64,
    parameter int                NUM_BLOCKS  = 8,
    parameter int                NUM_MASTERS = 1,
    parameter int                ADDR_W      = 10,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 10'h100
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [7:0]               reg_wdata,
    input  logic                     reg_wr,
    input  logic                     reg_rd,
    output logic [7:0]               reg_rdata,
    input  logic [NUM_BLOCKS*8-1:0]  pend_pad,
    input  logic [NUM_BLOCKS*8-1:0]  rt_pad,
    input  logic [NUM_MASTERS*8-1:0] master_vec,
    input  logic [7:0]               root,
    output logic [NUM_LINES-1:0]     cfg_we_vec,
    output logic [7:0]               cfg_byte
);
    logic [ADDR_W-1:0] off_full;
    logic [3:0]        off4;
    logic              in_rng;
    logic [7:0]        blksel_q;
    logic [7:0]        sel_pend, sel_rt, rd_mux, rdata_q;
    logic              cfg_go;
    logic [10:0]       line_sel;

    assign off_full = reg_addr - BASE_ADDR;
    assign off4     = off_full[3:0];
    assign in_rng   = (reg_addr >= BASE_ADDR) && ((off_full >> 4) == '0) && (off4 <= OFF_RT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            blksel_q <= '0;
        else if (reg_wr && in_rng && off4 == OFF_BSEL)
            blksel_q <= reg_wdata;
    end

    assign cfg_go   = reg_wr && in_rng && (off4 == OFF_CFG) && reg_wdata[CFG_WQ];
    assign line_sel = {blksel_q, reg_wdata[CFG_IDX+2:CFG_IDX]};
    assign cfg_byte = reg_wdata;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_we
        assign cfg_we_vec[i] = cfg_go && (line_sel == 11'(i));
    end

    always_comb begin
        sel_pend = '0;
        sel_rt   = '0;
        for (int b = 0; b < NUM_BLOCKS; b++) begin
            if (blksel_q == 8'(b)) begin
                sel_pend = pend_pad[b*8 +: 8];
                sel_rt   = rt_pad[b*8 +: 8];
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        if (in_rng) begin
            unique case (off4)
                OFF_ROOT: rd_mux = root;
                OFF_BSEL: rd_mux = blksel_q;
                OFF_LAT:  rd_mux = sel_pend;
                OFF_RT:   rd_mux = sel_rt;
                OFF_CFG:  rd_mux = '0;
                default: begin
                    for (int m = 0; m < NUM_MASTERS; m++) begin
                        if (off4 == (OFF_MST0 + 4'(m)))
                            rd_mux = master_vec[m*8 +: 8];
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (reg_rd)
            rdata_q <= rd_mux;
    end

    assign reg_rdata = rdata_q;
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
    import irqagg_pkg::*;
#(
    parameter int                NUM_LINES = 64,
    parameter int                ADDR_W    = 10,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] raw_in,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [7:0]           reg_wdata,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    output logic [7:0]           reg_rdata,
    output logic                 irq_out
);
    localparam int NUM_BLOCKS  = (NUM_LINES + 7) / 8;
    localparam int NUM_MASTERS = (NUM_BLOCKS + 7) / 8;
    localparam int PAD_LINES   = NUM_BLOCKS * 8;

    logic [NUM_LINES-1:0]     sync_vec;
    logic [NUM_LINES-1:0]     pend_vec;
    logic [PAD_LINES-1:0]     pend_pad;
    logic [PAD_LINES-1:0]     rt_pad;
    logic [NUM_MASTERS*8-1:0] master_vec;
    logic [7:0]               root;
    logic [NUM_LINES-1:0]     cfg_we_vec;
    logic [7:0]               cfg_byte;

    irqagg_sync #(.W(NUM_LINES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_in),
        .d_out (sync_vec)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        irqagg_line u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_in  (sync_vec[i]),
            .cfg_we   (cfg_we_vec[i]),
            .cfg_byte (cfg_byte),
            .pending  (pend_vec[i])
        );
    end

    for (genvar p = 0; p < PAD_LINES; p++) begin : g_pad
        if (p < NUM_LINES) begin : g_real
            assign pend_pad[p] = pend_vec[p];
            assign rt_pad[p]   = sync_vec[p];
        end else begin : g_fill
            assign pend_pad[p] = 1'b0;
            assign rt_pad[p]   = 1'b0;
        end
    end

    irqagg_tree #(
        .NUM_BLOCKS  (NUM_BLOCKS),
        .NUM_MASTERS (NUM_MASTERS)
    ) u_tree (
        .pend_pad   (pend_pad),
        .master_vec (master_vec),
        .root       (root),
        .irq        (irq_out)
    );

    irqagg_regs #(
        .NUM_LINES   (NUM_LINES),
        .NUM_BLOCKS  (NUM_BLOCKS),
        .NUM_MASTERS (NUM_MASTERS),
        .ADDR_W      (ADDR_W),
        .BASE_ADDR   (BASE_ADDR)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_rdata  (reg_rdata),
        .pend_pad   (pend_pad),
        .rt_pad     (rt_pad),
        .master_vec (master_vec),
        .root       (root),
        .cfg_we_vec (cfg_we_vec),
        .cfg_byte   (cfg_byte)
    );
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
    parameter int NUM_LINES = 64,
    parameter int PAD_LINES = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_rd,
    input logic [7:0]           reg_rdata,
    input logic                 irq_out,
    input logic [PAD_LINES-1:0] pend_pad,
    input logic [NUM_LINES-1:0] cfg_we_vec,
    input logic                 cfg_clr,
    input logic                 cfg_mfe,
    input logic                 cfg_mre,
    input logic                 cfg_wq
);
    // R11
    irq_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (|pend_pad));

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

    // R3
    one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cfg_we_vec));

    // R3
    qualify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_vec != '0) |-> cfg_wq);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_ln
        // R6
        clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we_vec[i] && cfg_clr) |=> !pend_pad[i]);

        // R7
        off_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we_vec[i] && cfg_mfe && cfg_mre) |=> !pend_pad[i]);
    end
endmodule

bind irqagg_top irqagg_chk #(
    .NUM_LINES (NUM_LINES),
    .PAD_LINES (PAD_LINES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_rd     (reg_rd),
    .reg_rdata  (reg_rdata),
    .irq_out    (irq_out),
    .pend_pad   (pend_pad),
    .cfg_we_vec (cfg_we_vec),
    .cfg_clr    (cfg_byte[3]),
    .cfg_mfe    (cfg_byte[1]),
    .cfg_mre    (cfg_byte[2]),
    .cfg_wq     (cfg_byte[7])
);

// File: tb/irqagg_top_tb.sv
module irqagg_top_tb;
    localparam int                NL   = 64;
    localparam int                AW   = 10;
    localparam logic [AW-1:0]     BASE = 10'h100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] raw_in = '0;
    logic [AW-1:0] reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [7:0]    reg_rdata;
    logic          irq_out;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    irqagg_top #(.NUM_LINES(NL), .ADDR_W(AW), .BASE_ADDR(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [3:0] off, input logic [7:0] d);
        reg_addr = BASE + AW'(off); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] off, output logic [7:0] d);
        reg_addr = BASE + AW'(off); reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    // config byte: bit7 qualify, 6:4 index, bit3 clear, bit2 rise/high mask, bit1 fall/low mask, bit0 level
    function automatic logic [7:0] cfgb(input int line, input bit lvl, input bit mfe, input bit mre, input bit clr);
        return {1'b1, 3'(line % 8), clr, mre, mfe, lvl};
    endfunction

    task automatic cfg(input int line, input bit lvl, input bit mfe, input bit mre, input bit clr);
        bus_wr(4'd5, 8'(line / 8));
        bus_wr(4'd7, cfgb(line, lvl, mfe, mre, clr));
    endtask

    function automatic bit exp_bit(input bit lvl, input bit mfe, input bit mre, input bit o, input bit n);
        if (mfe && mre) return 1'b0;
        if (lvl) return (!mre && (o || n)) || (!mfe && (!o || !n));
        return (!mre && !o && n) || (!mfe && o && !n);
    endfunction

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h5eed));
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk("R1 irq_out", 32'(irq_out), 0);
        chk("R1 rdata", 32'(reg_rdata), 0);
        bus_rd(4'd0, d); chk("R1 root", 32'(d), 0);
        raw_in[0] = 1'b1; idle(5);
        bus_rd(4'd6, d); chk("R1 latched blk0 after toggle", 32'(d), 0);

        // R4 rising edge on line 3, R11 latency
        cfg(3, 0, 1, 0, 1);
        raw_in[3] = 1'b1;
        idle(2); chk("R11 irq before third edge", 32'(irq_out), 0);
        idle(1); chk("R11 irq after third edge", 32'(irq_out), 1);
        bus_rd(4'd6, d); chk("R8 R4 latched blk0 rising", 32'(d), 32'h08);
        bus_wr(4'd7, cfgb(3, 0, 1, 0, 1));
        bus_rd(4'd6, d); chk("R6 clear line3", 32'(d), 0);
        raw_in[3] = 1'b0; idle(4);
        bus_rd(4'd6, d); chk("R4 falling ignored on rise-only", 32'(d), 0);

        // R4 falling edge on line 10
        cfg(10, 0, 0, 1, 1);
        raw_in[10] = 1'b1; idle(4);
        bus_rd(4'd6, d); chk("R4 rise ignored on fall-only", 32'(d), 0);
        raw_in[10] = 1'b0; idle(4);
        bus_rd(4'd6, d); chk("R4 falling latched blk1", 32'(d), 32'h04);
        bus_rd(4'd1, d); chk("R9 master0", 32'(d), 32'h02);
        bus_rd(4'd0, d); chk("R9 root bit1 only", 32'(d), 32'h02);
        // both edges
        cfg(10, 0, 0, 0, 1);
        raw_in[10] = 1'b1; idle(4);
        bus_rd(4'd6, d); chk("R4 both-edge rise", 32'(d), 32'h04);
        bus_wr(4'd7, cfgb(10, 0, 0, 0, 1));
        raw_in[10] = 1'b0; idle(4);
        bus_rd(4'd6, d); chk("R4 both-edge fall", 32'(d), 32'h04);
        // R7 disable
        bus_wr(4'd7, cfgb(10, 0, 1, 1, 0));
        bus_rd(4'd6, d); chk("R7 disable drops pending", 32'(d), 0);
        chk("R7 irq after disable", 32'(irq_out), 0);
        raw_in[10] = 1'b1; idle(4);
        bus_rd(4'd6, d); chk("R7 disabled no detect", 32'(d), 0);

        // R5 level high on line 20
        raw_in[20] = 1'b1; idle(4);
        cfg(20, 1, 1, 0, 1);
        chk("R5 pending 0 right after clear", 32'(irq_out), 0);
        idle(1); chk("R5 active-high latched", 32'(irq_out), 1);
        bus_wr(4'd7, cfgb(20, 1, 1, 0, 1));
        chk("R5 cleared cycle", 32'(irq_out), 0);
        idle(1); chk("R5 reasserts", 32'(irq_out), 1);
        raw_in[20] = 1'b0; idle(4);
        bus_wr(4'd7, cfgb(20, 1, 1, 0, 1)); idle(2);
        bus_rd(4'd6, d); chk("R5 inactive stays clear", 32'(d), 0);
        bus_wr(4'd7, cfgb(20, 1, 0, 1, 1)); idle(2);
        bus_rd(4'd6, d); chk("R5 active-low latched", 32'(d), 32'h10);
        bus_wr(4'd7, cfgb(20, 1, 1, 1, 0));

        // R3 unqualified write ignored (line 21)
        bus_wr(4'd7, 8'h54);
        raw_in[21] = 1'b1; idle(4);
        bus_rd(4'd6, d); chk("R3 unqualified write ignored", 32'(d), 0);

        // R12 invalid block select
        bus_wr(4'd5, 8'd8);
        bus_rd(4'd5, d); chk("R2 block select readback", 32'(d), 8);
        bus_wr(4'd7, 8'h85);
        bus_rd(4'd8, d); chk("R12 rt on missing block", 32'(d), 0);
        bus_rd(4'd6, d); chk("R12 latched on missing block", 32'(d), 0);
        raw_in[0] = 1'b0; idle(4); raw_in[0] = 1'b1; idle(4);
        bus_wr(4'd5, 8'd0);
        bus_rd(4'd6, d); chk("R12 line0 untouched", 32'(d), 0);
        bus_rd(4'd7, d); chk("R2 config port reads 0", 32'(d), 0);

        // R10 real-time status
        raw_in[47:40] = 8'hA5; idle(3);
        bus_wr(4'd5, 8'd5);
        bus_rd(4'd8, d); chk("R10 rt block5", 32'(d), 32'hA5);

        // R9 last line, absent masters
        cfg(63, 0, 1, 0, 1);
        raw_in[63] = 1'b1; idle(4);
        bus_rd(4'd1, d); chk("R9 master0 bit7", 32'(d), 32'h80);
        bus_rd(4'd0, d); chk("R9 root", 32'(d), 32'h02);
        bus_rd(4'd2, d); chk("R9 absent master reads 0", 32'(d), 0);
        chk("R11 irq line63", 32'(irq_out), 1);
        bus_rd(4'd9, d); chk("R2 out-of-range read", 32'(d), 0);

        // random phase: start with every line disabled
        for (int i = 0; i < NL; i++) cfg(i, 0, 1, 1, 0);
        chk("R7 all disabled irq", 32'(irq_out), 0);
        for (int r = 0; r < 24; r++) begin
            int b;
            logic [7:0] o, n, e, lv, mf, mr;
            b  = int'($urandom_range(7, 0));
            lv = 8'($urandom()); mf = 8'($urandom()); mr = 8'($urandom());
            o  = raw_in[b*8 +: 8];
            for (int k = 0; k < 8; k++) cfg(b*8 + k, lv[k], mf[k], mr[k], 1);
            idle(4);
            n = 8'($urandom());
            raw_in[b*8 +: 8] = n;
            idle(4);
            for (int k = 0; k < 8; k++) e[k] = exp_bit(lv[k], mf[k], mr[k], o[k], n[k]);
            bus_rd(4'd6, d); chk("R4 R5 R8 random latched", 32'(d), 32'(e));
            bus_rd(4'd8, d); chk("R10 random rt", 32'(d), 32'(n));
            bus_rd(4'd1, d); chk("R9 random master", 32'(d), (e != 0) ? (32'h1 << b) : 0);
            bus_rd(4'd0, d); chk("R9 random root", 32'(d), (e != 0) ? 32'h2 : 0);
            chk("R11 random irq", 32'(irq_out), 32'(e != 0));
            for (int k = 0; k < 8; k++) cfg(b*8 + k, 0, 1, 1, 0);
        end
        finish_run();
    end
endmodule